// File: doc/BRIEF.md
# Per-Core Priority Interrupt Delivery Gate

This block sits next to one processor core and decides, for every interrupt identifier it has been told about, whether the core should be interrupted now or whether the interrupt must wait. A small property table, written through a simple register port, holds an enable flag and a priority for each identifier. Arriving identifiers are latched into a pending vector. Combinational selection logic continuously searches that vector for the most urgent pending interrupt that is enabled and more urgent than the core's current running priority. The request line to the core is raised whenever such a candidate exists, the core interface is unmasked, and there is room to nest.

The running priority is tracked by hardware alone. An acknowledge from the core hands back the selected identifier, clears its pending flag, saves the old running priority on a small stack and adopts the new interrupt's priority. An end-of-interrupt restores the saved value. Because selection depends only on stored state and the mask, any change to the running priority, the mask or the table is re-evaluated automatically, with no new arrival needed. Numerically lower priority values are more urgent, and the idle running priority is all ones, so nothing is blocked at idle except an interrupt whose priority is itself all ones. When an acknowledge and an end-of-interrupt arrive together, the acknowledge is served and the end-of-interrupt is dropped.

Top module: `irq_gate`

## Requirements
- R1: After reset every identifier is disabled with priority all ones; a cycle with `cfg_we` high stores `cfg_en` and `cfg_prio` for `cfg_id`, and the new values govern selection from the next cycle.
- R2: A cycle with `in_valid` high marks `in_id` pending whatever its enable or priority; the mark stays until that identifier is acknowledged, and a disabled pending identifier never raises `irq_o`.
- R3: `irq_o` is high exactly when some pending, enabled identifier has a priority numerically below `run_prio`, `core_mask` is low, and the nesting stack is not full; an equal priority does not qualify.
- R4: `run_prio` resets to all ones (15 with 4-bit priority), has no write path, and changes only on a served acknowledge or an end-of-interrupt.
- R5: An `ack_req` cycle with `irq_o` high returns on `ack_id`, in that same cycle, the pending eligible identifier with the numerically lowest priority, ties going to the lowest identifier; on the next cycle its pending mark is cleared and `run_prio` equals its priority.
- R6: An `ack_req` cycle with `irq_o` low (no eligible candidate, mask set, or stack of `STACK_DEPTH` entries full) returns the spurious code, all ones of `ack_id` (31 with 16 identifiers), and changes neither `run_prio` nor any pending mark.
- R7: `eoi_req` restores `run_prio` to the value saved by the most recent served acknowledge; with no saved value it is ignored and `run_prio` stays all ones.
- R8: A pending interrupt held back by priority, mask or a disabled entry raises `irq_o` without any new arrival as soon as `run_prio` rises through end-of-interrupt, `core_mask` drops, or its table entry becomes enabled.
- R9: When an identifier arrives in the same cycle in which it is acknowledged, its pending mark remains set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Property table write strobe |
| cfg_id | input | IDX_W | Identifier whose properties are written |
| cfg_en | input | 1 | Enable flag to store |
| cfg_prio | input | PRIO_W | Priority to store (lower is more urgent) |
| in_valid | input | 1 | An interrupt arrives this cycle |
| in_id | input | IDX_W | Identifier of the arriving interrupt |
| core_mask | input | 1 | Core interface mask, high blocks delivery |
| ack_req | input | 1 | Core acknowledges the request |
| eoi_req | input | 1 | Core ends the active interrupt |
| irq_o | output | 1 | Interrupt request line to the core |
| ack_id | output | IDX_W+1 | Identifier returned for an acknowledge, or spurious code |
| run_prio | output | PRIO_W | Current running priority |

## Verification
The embedded properties watch, on every cycle, that the running priority rests at the idle value whenever no priority is saved, that it moves only on acknowledge or end-of-interrupt, that each served acknowledge strictly raises urgency, that an acknowledged identifier loses its pending mark, that an unserved acknowledge leaves the running priority alone, and that the nesting stack never overflows. What they cannot show is that the right identifier wins: the urgency and lowest-identifier tie-break, the exact-equality boundary against the running priority, the re-evaluation after unmask, enable or end-of-interrupt, the stack-full refusal and the same-cycle arrival during acknowledge are shown only by the bench's scenarios against its scoreboard of expected identifiers.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    // Operation applied to the saved-priority stack in a cycle.
    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

    // Widest priority the block supports; narrower builds zero-extend.
    localparam int unsigned PRIO_MAX_W = 8;
    localparam int unsigned PRIO_MIN_W = 3;

    // True when priority a is strictly more urgent than priority b.
    function automatic logic more_urgent(input logic [PRIO_MAX_W-1:0] a,
                                         input logic [PRIO_MAX_W-1:0] b);
        return a < b;
    endfunction

endpackage

// File: rtl/irq_gate_prop_table.sv
module irq_gate_prop_table
    import irq_gate_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 16,
    parameter int unsigned PRIO_W  = 4,
    localparam int unsigned IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we,
    input  logic [IDX_W-1:0]                wid,
    input  logic                            wen,
    input  logic [PRIO_W-1:0]               wprio,
    output logic [NUM_IRQ-1:0]              en_vec,
    output logic [NUM_IRQ-1:0][PRIO_W-1:0]  prio_tab
);

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                en_vec[g]   <= 1'b0;
                prio_tab[g] <= '1;
            end else if (we && (wid == IDX_W'(g))) begin
                en_vec[g]   <= wen;
                prio_tab[g] <= wprio;
            end
        end
    end

    // R1: a write lands exactly in the addressed entry
    p_table_write_r1: assert property (@(posedge clk) disable iff (rst)
        we |=> (en_vec[$past(wid)] == $past(wen)) && (prio_tab[$past(wid)] == $past(wprio)));

endmodule

// File: rtl/irq_gate_pend.sv
module irq_gate_pend #(
    parameter int unsigned NUM_IRQ = 16,
    localparam int unsigned IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set_vld,
    input  logic [IDX_W-1:0]   set_id,
    input  logic               clr_vld,
    input  logic [IDX_W-1:0]   clr_id,
    output logic [NUM_IRQ-1:0] pend
);

    logic [NUM_IRQ-1:0] set_mask;
    logic [NUM_IRQ-1:0] clr_mask;

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (set_vld) set_mask[set_id] = 1'b1;
        if (clr_vld) clr_mask[clr_id] = 1'b1;
    end

    // A new arrival wins over a clear of the same identifier.
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr_mask) | set_mask;
    end

    // R5: an acknowledged identifier is no longer pending afterwards
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_vld && !(set_vld && (set_id == clr_id))) |=> !pend[$past(clr_id)]);

    // R9: an arrival colliding with its own acknowledge stays pending
    p_collide_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_vld && set_vld && (set_id == clr_id)) |=> pend[$past(clr_id)]);

    // R2: an arrival is always recorded
    p_arrival_marks_r2: assert property (@(posedge clk) disable iff (rst)
        set_vld |=> pend[$past(set_id)]);

endmodule

// File: rtl/irq_gate_pick.sv
module irq_gate_pick
    import irq_gate_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 16,
    parameter int unsigned PRIO_W  = 4,
    localparam int unsigned IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0]             pend,
    input  logic [NUM_IRQ-1:0]             en_vec,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_tab,
    input  logic [PRIO_W-1:0]              limit,
    output logic                           found,
    output logic [IDX_W-1:0]               best_id,
    output logic [PRIO_W-1:0]              best_prio
);

    logic [NUM_IRQ-1:0] cand;

    // An identifier is a candidate only if strictly more urgent than the limit.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_cand
        assign cand[g] = pend[g] && en_vec[g] &&
                         more_urgent(PRIO_MAX_W'(prio_tab[g]), PRIO_MAX_W'(limit));
    end

    // Scan upward; only a strictly better priority replaces the holder,
    // so equal priorities leave the lowest identifier in place.
    always_comb begin
        found     = 1'b0;
        best_id   = '0;
        best_prio = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (cand[i] && (!found ||
                more_urgent(PRIO_MAX_W'(prio_tab[i]), PRIO_MAX_W'(best_prio)))) begin
                found     = 1'b1;
                best_id   = IDX_W'(i);
                best_prio = prio_tab[i];
            end
        end
    end

endmodule

// File: rtl/irq_gate_stack.sv
module irq_gate_stack
    import irq_gate_pkg::*;
#(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned PRIO_W = 4,
    localparam int unsigned CW    = $clog2(DEPTH + 1),
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  stk_op_e           op,
    input  logic [PRIO_W-1:0] push_val,
    output logic [PRIO_W-1:0] top_val,
    output logic              empty,
    output logic              full
);

    logic [PRIO_W-1:0] mem [DEPTH];
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     cnt_m1;

    assign cnt_m1  = cnt - CW'(1);
    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign top_val = empty ? '1 : mem[cnt_m1[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            unique case (op)
                STK_PUSH: if (!full) begin
                    mem[cnt[AW-1:0]] <= push_val;
                    cnt              <= cnt + CW'(1);
                end
                STK_POP: if (!empty) cnt <= cnt_m1;
                default: ;
            endcase
        end
    end

    // R6: the saved-priority stack never grows past its depth
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R6: no push is ever requested when the stack is full
    p_no_push_full_r6: assert property (@(posedge clk) disable iff (rst)
        full |-> (op != STK_PUSH));

endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import irq_gate_pkg::*;
#(
    parameter int unsigned NUM_IRQ     = 16,
    parameter int unsigned PRIO_W      = 4,
    parameter int unsigned STACK_DEPTH = 4,
    localparam int unsigned IDX_W      = $clog2(NUM_IRQ),
    localparam int unsigned AID_W      = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_id,
    input  logic              cfg_en,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_id,
    input  logic              core_mask,
    input  logic              ack_req,
    input  logic              eoi_req,
    output logic              irq_o,
    output logic [AID_W-1:0]  ack_id,
    output logic [PRIO_W-1:0] run_prio
);

    localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;
    localparam logic [AID_W-1:0]  SPUR_ID   = '1;

    if (PRIO_W < PRIO_MIN_W || PRIO_W > PRIO_MAX_W) begin : g_bad_prio
        initial $error("PRIO_W outside supported range");
    end

    logic [NUM_IRQ-1:0]             en_vec;
    logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_tab;
    logic [NUM_IRQ-1:0]             pend;
    logic                           found;
    logic [IDX_W-1:0]               best_id;
    logic [PRIO_W-1:0]              best_prio;
    logic [PRIO_W-1:0]              saved_prio;
    logic                           stk_empty;
    logic                           stk_full;
    logic                           grant;
    stk_op_e                        stk_op;

    irq_gate_prop_table #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) i_table (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .wid      (cfg_id),
        .wen      (cfg_en),
        .wprio    (cfg_prio),
        .en_vec   (en_vec),
        .prio_tab (prio_tab)
    );

    irq_gate_pend #(.NUM_IRQ(NUM_IRQ)) i_pend (
        .clk     (clk),
        .rst     (rst),
        .set_vld (in_valid),
        .set_id  (in_id),
        .clr_vld (grant),
        .clr_id  (best_id),
        .pend    (pend)
    );

    irq_gate_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) i_pick (
        .pend      (pend),
        .en_vec    (en_vec),
        .prio_tab  (prio_tab),
        .limit     (run_prio),
        .found     (found),
        .best_id   (best_id),
        .best_prio (best_prio)
    );

    irq_gate_stack #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W)) i_stack (
        .clk      (clk),
        .rst      (rst),
        .op       (stk_op),
        .push_val (run_prio),
        .top_val  (saved_prio),
        .empty    (stk_empty),
        .full     (stk_full)
    );

    // Deliverable only when a candidate exists, the core is open and nesting room remains.
    assign irq_o  = found && !core_mask && !stk_full;
    assign grant  = ack_req && irq_o;
    assign ack_id = grant ? AID_W'(best_id) : SPUR_ID;

    always_comb begin
        if (grant)                   stk_op = STK_PUSH;
        else if (eoi_req && !stk_empty && !ack_req) stk_op = STK_POP;
        else                         stk_op = STK_HOLD;
    end

    // Running priority: no write path, moves only on served acknowledge or pop.
    always_ff @(posedge clk) begin
        if (rst) begin
            run_prio <= IDLE_PRIO;
        end else begin
            unique case (stk_op)
                STK_PUSH: run_prio <= best_prio;
                STK_POP:  run_prio <= saved_prio;
                default:  ;
            endcase
        end
    end

    // R4: with nothing saved the running priority rests at idle
    p_idle_empty_r4: assert property (@(posedge clk) disable iff (rst)
        stk_empty |-> (run_prio == IDLE_PRIO));

    // R4: without acknowledge or end-of-interrupt the running priority holds
    p_prio_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!ack_req && !eoi_req) |=> $stable(run_prio));

    // R5: a served acknowledge makes the running priority strictly more urgent
    p_nest_urgent_r5: assert property (@(posedge clk) disable iff (rst)
        grant |=> (run_prio < $past(run_prio)));

    // R6: an unserved acknowledge leaves the running priority untouched
    p_spurious_still_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_req && !irq_o && !eoi_req) |=> $stable(run_prio));

    // R7: end-of-interrupt on an empty stack keeps the idle value
    p_eoi_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (eoi_req && !ack_req && stk_empty) |=> (run_prio == IDLE_PRIO));

endmodule

// File: tb/test_irq_gate.sv
module test_irq_gate;

    localparam int NUM_IRQ = 16;
    localparam int PRIO_W  = 4;
    localparam int DEPTH   = 4;
    localparam int IDX_W   = $clog2(NUM_IRQ);
    localparam int AID_W   = IDX_W + 1;
    localparam int SPUR    = 31;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [IDX_W-1:0]  cfg_id = '0;
    logic              cfg_en = 1'b0;
    logic [PRIO_W-1:0] cfg_prio = '0;
    logic              in_valid = 1'b0;
    logic [IDX_W-1:0]  in_id = '0;
    logic              core_mask = 1'b0;
    logic              ack_req = 1'b0;
    logic              eoi_req = 1'b0;
    logic              irq_o;
    logic [AID_W-1:0]  ack_id;
    logic [PRIO_W-1:0] run_prio;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int    exp_q[$];
    string tag_q[$];

    irq_gate #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .STACK_DEPTH(DEPTH)) i_irq_gate (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_en(cfg_en),
        .cfg_prio(cfg_prio), .in_valid(in_valid), .in_id(in_id), .core_mask(core_mask),
        .ack_req(ack_req), .eoi_req(eoi_req), .irq_o(irq_o), .ack_id(ack_id),
        .run_prio(run_prio)
    );

    always #10 clk = ~clk;

    // Monitor: compares the returned identifier during each acknowledge cycle.
    always @(negedge clk) begin
        #2;
        if (ack_req) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL ack without expectation: actual=%0d expected=none", ack_id);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (int'(ack_id) != e) begin
                    bad++;
                    $display("FAIL %s ack_id: actual=%0d expected=%0d", t, ack_id, e);
                end
            end
        end
    end

    task automatic check(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_irq(input int exp, input string tag);
        #3 check(int'(irq_o), exp, {tag, " irq_o"});
    endtask

    task automatic chk_run(input int exp, input string tag);
        #3 check(int'(run_prio), exp, {tag, " run_prio"});
    endtask

    task automatic cfg(input int id, input bit en, input int prio);
        @(negedge clk);
        cfg_we = 1'b1; cfg_id = IDX_W'(id); cfg_en = en; cfg_prio = PRIO_W'(prio);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic raise(input int id);
        @(negedge clk);
        in_valid = 1'b1; in_id = IDX_W'(id);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic ack(input int exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
    endtask

    task automatic raise_ack(input int id, input int exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        in_valid = 1'b1; in_id = IDX_W'(id); ack_req = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; ack_req = 1'b0;
    endtask

    task automatic eoi();
        @(negedge clk);
        eoi_req = 1'b1;
        @(negedge clk);
        eoi_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_irq(0, "R4 reset");
        chk_run(15, "R4 reset");
        ack(SPUR, "R6 idle spurious");

        cfg(3, 1, 5); cfg(7, 1, 5); cfg(9, 1, 2); cfg(12, 0, 1); cfg(4, 1, 15);

        // Disabled entry and a priority equal to idle never deliver.
        raise(12); raise(4);
        chk_irq(0, "R2 disabled/equal");

        raise(7); raise(3);
        chk_irq(1, "R3 eligible");
        ack(3, "R5 tie lowest id");
        chk_run(5, "R5 adopt prio");
        chk_irq(0, "R3 equal blocks");

        raise(9);
        chk_irq(1, "R3 more urgent");
        ack(9, "R5 nested");
        chk_run(2, "R5 nested");

        eoi();
        chk_run(5, "R7 restore");
        chk_irq(0, "R3 still equal");
        eoi();
        chk_run(15, "R7 restore idle");
        chk_irq(1, "R8 after eoi");
        ack(7, "R5 remaining");
        eoi();

        core_mask = 1'b1;
        raise(3);
        chk_irq(0, "R3 masked");
        ack(SPUR, "R6 masked");
        chk_run(15, "R6 masked");
        @(negedge clk);
        core_mask = 1'b0;
        chk_irq(1, "R8 unmask");

        cfg(12, 1, 1);
        ack(12, "R8 enabled later / R1");
        chk_run(1, "R5 prio 1");
        ack(SPUR, "R6 no candidate");
        chk_run(1, "R6 no change");
        eoi();
        ack(3, "R6 pending kept");
        eoi();
        chk_irq(0, "R2 only id4 left");

        cfg(0, 1, 4); cfg(1, 1, 3); cfg(2, 1, 2); cfg(5, 1, 1); cfg(6, 1, 0);
        raise(0); ack(0, "R5 fill");
        raise(1); ack(1, "R5 fill");
        raise(2); ack(2, "R5 fill");
        raise(5); ack(5, "R5 fill");
        chk_run(1, "R5 fill");
        raise(6);
        chk_irq(0, "R6 stack full");
        ack(SPUR, "R6 stack full");
        chk_run(1, "R6 stack full");
        eoi();
        chk_run(2, "R7 pop");
        chk_irq(1, "R8 room again");
        ack(6, "R5 most urgent");
        chk_run(0, "R5 prio 0");
        for (int k = 0; k < 4; k++) eoi();
        chk_run(15, "R7 unwound");
        eoi();
        chk_run(15, "R7 empty eoi ignored");

        // Same-cycle arrival during its own acknowledge.
        raise(3);
        raise_ack(3, 3, "R9 collide");
        chk_irq(0, "R9 blocked by own prio");
        eoi();
        chk_irq(1, "R9 still pending");
        ack(3, "R9 second instance");
        eoi();

        repeat (3) @(negedge clk);
        check(exp_q.size(), 0, "R5 scoreboard drained");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule